// File: doc/BRIEF.md
# Atomic Bus Lock Controller

This block watches the accesses that hit one memory bank and decides when the bus must be held for a single master so that it can finish an atomic pair of accesses. The bank's 2-bit atomic mode picks one of two orderings. In one, a write takes the lock and a later read by the same master gives it back. In the other, a read takes the lock and a later write gives it back. When the lock is set, the block also records which master owns it. An arbiter outside this block reads the lock and owner outputs and refuses the bus to everyone else.

If the owner never finishes its pair, a watchdog forces the lock off after a fixed number of clock cycles and raises a one-cycle timeout pulse. The release direction is captured when the lock is taken. Changing the mode while the bus is locked therefore does not change how the current lock ends.

The controller is a three-state machine: IDLE, LOCKED and EXPIRED. Four transitions connect the states:
- **take** moves IDLE or EXPIRED to LOCKED when a qualifying access arrives.
- **release** moves LOCKED to IDLE when the owner makes an access in the opposite direction.
- **expire** moves LOCKED to EXPIRED when the watchdog runs out.
- **settle** moves EXPIRED to IDLE when no qualifying access arrives during the pulse cycle.

Top module: `atomic_lock_ctrl`

## Requirements
- R1: While synchronous active-high `rst` is high, and in the cycle after it falls, `lock_o`, `owner_o` and `timeout_o` are all 0.
- R2: With mode 2'b01 and the bus not locked, a hit with `wr_i`=1 (write) makes `lock_o` 1 after the next clock edge, with `owner_o` equal to that access's `master_i`. A later hit by the owner with `wr_i`=0 (read) makes `lock_o` 0 after the next edge, with no timeout pulse.
- R3: With mode 2'b10, a read hit takes the lock in the same way, and a later write hit by the owner releases it.
- R4: With mode 2'b00, hits in either direction never set the lock.
- R5: Mode 2'b11 acts like 2'b00 for locking, and `cfg_err_o` is 1 in every cycle where `mode_i` is 2'b11. `cfg_err_o` is 0 for the other modes. The output is combinational.
- R6: While the bus is locked, hits by any master other than the owner neither release the lock nor restart the watchdog.
- R7: A repeat of the lock-taking access by the owner while the bus is locked does not restart the watchdog.
- R8: If the lock is not released, `lock_o` stays 1 for exactly TIMEOUT_CYCLES (default 256) cycles. It then drops, and `timeout_o` is 1 for exactly that one following cycle.
- R9: A qualifying hit in the cycle where `timeout_o` is 1 takes a new lock at the next edge. After a timeout, the bus is otherwise unlocked.
- R10: An owner release in the last locked cycle wins over the watchdog: the lock drops and `timeout_o` stays 0.
- R11: The release direction is the one fixed when the lock was taken. A mode change during a lock does not alter which access releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Atomic mode of the bank: 00 none, 01 write-locks/read-releases, 10 read-locks/write-releases, 11 reserved |
| hit_i | input | 1 | An access hits this bank in this cycle |
| wr_i | input | 1 | Access direction, 1 = write, 0 = read |
| master_i | input | MASTER_W | ID of the accessing master |
| lock_o | output | 1 | Bus is locked for the owner |
| owner_o | output | MASTER_W | Owner ID while locked, 0 otherwise |
| timeout_o | output | 1 | One-cycle pulse after a forced release |
| cfg_err_o | output | 1 | Reserved mode selected |

## Verification
A wrong state shows at the ports one clock after the access that should have moved the machine. A missed take or release appears as `lock_o` at the wrong level in the next cycle. A wrong owner appears on `owner_o` at the same time. Watchdog faults stay hidden for up to TIMEOUT_CYCLES: a counter that restarts, or one that does not clear, only shows when the pulse comes early, comes late, or never comes. For that reason every lock test is run all the way to its expected pulse cycle, and the exact cycle is checked.

// File: rtl/atl_pkg.sv
package atl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_EXPIRED = 2'd2
    } atl_state_e;

    typedef enum logic [1:0] {
        AM_NONE = 2'b00,
        AM_WLRR = 2'b01,
        AM_RLWR = 2'b10,
        AM_RSVD = 2'b11
    } atl_mode_e;

endpackage

// File: rtl/atl_mode_decode.sv
module atl_mode_decode
    import atl_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       lock_on_wr_o,
    output logic       lock_on_rd_o,
    output logic       cfg_err_o
);

    always_comb begin
        lock_on_wr_o = 1'b0;
        lock_on_rd_o = 1'b0;
        cfg_err_o    = 1'b0;
        unique case (atl_mode_e'(mode_i))
            AM_NONE: ;
            AM_WLRR: lock_on_wr_o = 1'b1;
            AM_RLWR: lock_on_rd_o = 1'b1;
            AM_RSVD: cfg_err_o    = 1'b1;
        endcase
    end

endmodule

// File: rtl/atl_timer.sv
module atl_timer #(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);

    localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Counts locked cycles; zero in the first locked cycle.
    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/atl_fsm.sv
module atl_fsm
    import atl_pkg::*;
#(
    parameter int MASTER_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit_i,
    input  logic                wr_i,
    input  logic [MASTER_W-1:0] master_i,
    input  logic                lock_on_wr_i,
    input  logic                lock_on_rd_i,
    input  logic                expire_i,
    output logic                run_o,
    output logic                lock_o,
    output logic [MASTER_W-1:0] owner_o,
    output logic                timeout_o
);

    atl_state_e          state_q, state_d;
    logic [MASTER_W-1:0] owner_q, owner_d;
    logic                took_wr_q, took_wr_d;
    logic                take, release_hit;

    assign take        = hit_i && ((wr_i && lock_on_wr_i) || (!wr_i && lock_on_rd_i));
    assign release_hit = hit_i && (master_i == owner_q) && (wr_i != took_wr_q);

    // Next-state logic.
    always_comb begin
        state_d   = state_q;
        owner_d   = owner_q;
        took_wr_d = took_wr_q;
        unique case (state_q)
            ST_IDLE, ST_EXPIRED: begin
                if (take) begin
                    state_d   = ST_LOCKED;
                    owner_d   = master_i;
                    took_wr_d = wr_i;
                end else begin
                    state_d   = ST_IDLE;
                end
            end
            ST_LOCKED: begin
                if (release_hit) begin
                    state_d = ST_IDLE;
                end else if (expire_i) begin
                    state_d = ST_EXPIRED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            owner_q   <= '0;
            took_wr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            owner_q   <= owner_d;
            took_wr_q <= took_wr_d;
        end
    end

    // Outputs.
    always_comb begin
        lock_o    = 1'b0;
        run_o     = 1'b0;
        timeout_o = 1'b0;
        owner_o   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOCKED: begin
                lock_o  = 1'b1;
                run_o   = 1'b1;
                owner_o = owner_q;
            end
            ST_EXPIRED: timeout_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl #(
    parameter int MASTER_W       = 4,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic                hit_i,
    input  logic                wr_i,
    input  logic [MASTER_W-1:0] master_i,
    output logic                lock_o,
    output logic [MASTER_W-1:0] owner_o,
    output logic                timeout_o,
    output logic                cfg_err_o
);

    logic lock_on_wr, lock_on_rd, run, expire;

    atl_mode_decode u_dec (
        .mode_i       (mode_i),
        .lock_on_wr_o (lock_on_wr),
        .lock_on_rd_o (lock_on_rd),
        .cfg_err_o    (cfg_err_o)
    );

    atl_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .expire_o (expire)
    );

    atl_fsm #(.MASTER_W(MASTER_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .hit_i        (hit_i),
        .wr_i         (wr_i),
        .master_i     (master_i),
        .lock_on_wr_i (lock_on_wr),
        .lock_on_rd_i (lock_on_rd),
        .expire_i     (expire),
        .run_o        (run),
        .lock_o       (lock_o),
        .owner_o      (owner_o),
        .timeout_o    (timeout_o)
    );

endmodule

// File: rtl/atl_checker.sv
module atl_checker #(
    parameter int MASTER_W       = 4,
    parameter int TIMEOUT_CYCLES = 256
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode_i,
    input logic                hit_i,
    input logic                wr_i,
    input logic [MASTER_W-1:0] master_i,
    input logic                lock_o,
    input logic [MASTER_W-1:0] owner_o,
    input logic                timeout_o
);

    localparam int WW = $clog2(TIMEOUT_CYCLES + 1) + 1;
    logic [WW-1:0] win_q;

    always_ff @(posedge clk) begin
        if (rst || !lock_o) win_q <= '0;
        else                win_q <= win_q + WW'(1);
    end

    // R2
    a_r2_write_takes: assert property (@(posedge clk) disable iff (rst)
        (!lock_o && hit_i && mode_i == 2'b01 && wr_i) |=> (lock_o && owner_o == $past(master_i)));

    // R3
    a_r3_read_takes: assert property (@(posedge clk) disable iff (rst)
        (!lock_o && hit_i && mode_i == 2'b10 && !wr_i) |=> (lock_o && owner_o == $past(master_i)));

    // R4, R5
    a_r4_quiet_modes: assert property (@(posedge clk) disable iff (rst)
        (!lock_o && (mode_i == 2'b00 || mode_i == 2'b11)) |=> !lock_o);

    // R6
    a_r6_others_ignored: assert property (@(posedge clk) disable iff (rst)
        (lock_o && (!hit_i || master_i != owner_o)) |=> (lock_o || timeout_o));

    a_r6_owner_held: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> (!lock_o || $stable(owner_o)));

    // R8
    a_r8_window_bound: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> (win_q < WW'(TIMEOUT_CYCLES)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    a_r8_pulse_after_lock: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (!lock_o && $past(lock_o)));

endmodule

bind atomic_lock_ctrl atl_checker #(
    .MASTER_W       (MASTER_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_atl_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .hit_i     (hit_i),
    .wr_i      (wr_i),
    .master_i  (master_i),
    .lock_o    (lock_o),
    .owner_o   (owner_o),
    .timeout_o (timeout_o)
);

// File: tb/tb_atomic_lock_ctrl.sv
`timescale 1ns/1ps
module tb_atomic_lock_ctrl;

    localparam int MW = 4;
    localparam int TO = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode;
    logic          hit, wr;
    logic [MW-1:0] mst;
    logic          lock, tmo, cerr;
    logic [MW-1:0] owner;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    atomic_lock_ctrl #(.MASTER_W(MW), .TIMEOUT_CYCLES(TO)) dut (
        .clk(clk), .rst(rst), .mode_i(mode), .hit_i(hit), .wr_i(wr),
        .master_i(mst), .lock_o(lock), .owner_o(owner),
        .timeout_o(tmo), .cfg_err_o(cerr)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive for one clock; returns at the following falling edge.
    task automatic apply(logic h, logic w, logic [MW-1:0] m, logic [1:0] md);
        hit = h; wr = w; mst = m; mode = md;
        @(negedge clk);
    endtask

    // Called with 'used' cycles already spent in the lock.
    task automatic run_to_pulse(int used, logic [1:0] md, string tag);
        for (int i = used; i < TO - 1; i++) apply(0, 0, 0, md);
        check({tag, " lock held last cycle"}, lock, 1);
        apply(0, 0, 0, md);
        check({tag, " lock dropped"}, lock, 0);
        check({tag, " timeout pulse"}, tmo, 1);
    endtask

    task automatic t_reset();
        rst = 1; hit = 0; wr = 0; mst = 0; mode = 0;
        repeat (3) @(negedge clk);
        check("R1 lock in reset", lock, 0);
        rst = 0;
        @(negedge clk);
        check("R1 lock", lock, 0);
        check("R1 owner", owner, 0);
        check("R1 timeout", tmo, 0);
    endtask

    task automatic t_write_lock();
        apply(1, 1, 3, 2'b01);
        check("R2 lock taken", lock, 1);
        check("R2 owner", owner, 3);
        for (int i = 0; i < 5; i++) apply(0, 0, 0, 2'b01);
        check("R2 lock held", lock, 1);
        apply(1, 0, 3, 2'b01);
        check("R2 released", lock, 0);
        check("R2 no pulse", tmo, 0);
        check("R2 owner cleared", owner, 0);
    endtask

    task automatic t_read_lock();
        apply(1, 0, 9, 2'b10);
        check("R3 lock taken", lock, 1);
        check("R3 owner", owner, 9);
        apply(1, 0, 9, 2'b10);
        check("R3 read keeps lock", lock, 1);
        apply(1, 1, 9, 2'b10);
        check("R3 released", lock, 0);
        check("R3 no pulse", tmo, 0);
    endtask

    task automatic t_none_mode();
        apply(1, 1, 2, 2'b00);
        check("R4 write no lock", lock, 0);
        apply(1, 0, 2, 2'b00);
        check("R4 read no lock", lock, 0);
        check("R4 no cfg err", cerr, 0);
    endtask

    task automatic t_rsvd_mode();
        mode = 2'b11; hit = 0;
        #1;
        check("R5 cfg err", cerr, 1);
        apply(1, 1, 4, 2'b11);
        check("R5 write no lock", lock, 0);
        apply(1, 0, 4, 2'b11);
        check("R5 read no lock", lock, 0);
        mode = 2'b10;
        #1;
        check("R5 cfg err clear", cerr, 0);
        apply(0, 0, 0, 2'b10);
    endtask

    task automatic t_other_master();
        apply(1, 1, 4, 2'b01);
        check("R6 lock taken", lock, 1);
        for (int i = 0; i < 50; i++) apply(0, 0, 0, 2'b01);
        apply(1, 0, 7, 2'b01);
        check("R6 other read ignored", lock, 1);
        check("R6 owner kept", owner, 4);
        apply(1, 1, 7, 2'b01);
        check("R6 other write ignored", owner, 4);
        run_to_pulse(52, 2'b01, "R6");
        apply(0, 0, 0, 2'b01);
        check("R8 pulse one cycle", tmo, 0);
    endtask

    task automatic t_repeat_take();
        apply(1, 0, 2, 2'b10);
        for (int i = 0; i < 100; i++) apply(0, 0, 0, 2'b10);
        apply(1, 0, 2, 2'b10);
        check("R7 repeat keeps lock", lock, 1);
        run_to_pulse(101, 2'b10, "R7");
        apply(0, 0, 0, 2'b10);
    endtask

    task automatic t_timeout_retake();
        apply(1, 1, 8, 2'b01);
        run_to_pulse(0, 2'b01, "R8");
        apply(1, 1, 6, 2'b01);
        check("R9 retake in pulse", lock, 1);
        check("R9 new owner", owner, 6);
        check("R9 pulse gone", tmo, 0);
        apply(1, 0, 6, 2'b01);
        check("R9 release after retake", lock, 0);
    endtask

    task automatic t_last_cycle_release();
        apply(1, 0, 1, 2'b10);
        for (int i = 0; i < TO - 1; i++) apply(0, 0, 0, 2'b10);
        check("R10 still locked", lock, 1);
        apply(1, 1, 1, 2'b10);
        check("R10 released", lock, 0);
        check("R10 no pulse", tmo, 0);
        apply(0, 0, 0, 2'b10);
        check("R10 no late pulse", tmo, 0);
    endtask

    task automatic t_mode_change();
        apply(1, 1, 5, 2'b01);
        check("R11 lock taken", lock, 1);
        apply(1, 1, 5, 2'b10);
        check("R11 write keeps lock", lock, 1);
        apply(1, 0, 5, 2'b10);
        check("R11 read releases", lock, 0);
        check("R11 no pulse", tmo, 0);
    endtask

    initial begin
        t_reset();
        t_write_lock();
        t_read_lock();
        t_none_mode();
        t_rsvd_mode();
        t_other_master();
        t_repeat_take();
        t_timeout_retake();
        t_last_cycle_release();
        t_mode_change();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule